// File: doc/BRIEF.md
# Interrupt Acknowledge Vectoring Sequencer

Once the core has decided to take an interrupt, this block works out how to reach the service routine and drives the bus activity that gets there. It issues a series of bus cycle requests, and a bus sequencer carries each one out. The request types are acknowledge, memory write and bus idle. An acknowledge cycle returns a byte from the interrupting device. When that byte is a single-byte restart code, the routine address comes from a 3-bit field of the code. When the byte is the call opcode, two more acknowledge cycles collect the low and high bytes of the target address. A trap does not involve the device at all. It spends one bus-idle cycle and then uses a fixed vector.

On every valid path, the interrupted program counter is saved on the stack by two memory-write cycles. Any other first byte ends the sequence with an error flag, and the program counter and stack pointer are left as they were. A single-cycle done pulse presents the new program counter and stack pointer, which the core loads.

Top module: `iav_seq`

## Requirements
- R1: After reset, `req_valid_o`, `busy_o`, `done_o` and `err_o` are low. No request is raised while `busy_o` is low.
- R2: `start_i` while idle with `trap_i` low captures `pc_i` and `sp_i`. On the next cycle it raises an acknowledge request (kind 2'b01) at the captured PC, with data 8'h00.
- R3: A first byte of the form 2'b11,nnn,3'b111 (bits 7:6 high, bits 2:0 high) is a restart. It is followed by the two pushes of R5, and the new PC is nnn times 8.
- R4: A first byte equal to the call opcode (default 8'hCD) is followed by two more acknowledge requests at the same address. The first returns the low target byte and the second the high byte. The two pushes of R5 follow, and the new PC is {high, low}.
- R5: Each push decrements the stack pointer before writing. The first write (kind 2'b10) goes to SP-1 and carries PC[15:8]. The second goes to SP-2 and carries PC[7:0]. The new stack pointer is SP-2, with 16-bit wraparound.
- R6: `start_i` with `trap_i` high issues one bus-idle request (kind 2'b11) at the captured PC and no acknowledge request. It is followed by the R5 pushes, and the new PC is 16'h0024.
- R7: Any other first byte ends the sequence with `err_o` high, no write requests, new PC equal to the captured PC and new SP equal to the captured SP.
- R8: A request completes only in a cycle where `req_done_i` is high. Until then, its kind, address and data hold steady, for any number of wait cycles.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final request completes. `new_pc_o`, `new_sp_o` and `err_o` are valid while `done_o` is high.
- R10: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Interrupt accepted; begin a sequence |
| trap_i | input | 1 | Sequence is for the internally vectored trap |
| pc_i | input | 16 | Program counter to be saved |
| sp_i | input | 16 | Stack pointer at start |
| req_valid_o | output | 1 | A bus cycle request is pending |
| req_kind_o | output | 2 | 01 acknowledge, 10 memory write, 11 bus idle |
| req_addr_o | output | 16 | Address for the requested cycle |
| req_data_o | output | 8 | Write data for memory-write requests |
| req_done_i | input | 1 | Bus sequencer completes the pending request this cycle |
| ack_data_i | input | 8 | Byte returned by an acknowledge cycle, valid with `req_done_i` |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completed sequence hit an unsupported byte |
| new_pc_o | output | 16 | Program counter to load |
| new_sp_o | output | 16 | Stack pointer to load |

## Verification
The assertions assume that the bus sequencer raises `req_done_i` only while a request is pending. They also assume that `ack_data_i` is meaningful only in the completing cycle of an acknowledge request. The bench's responder keeps to both rules: it pulses `req_done_i` only after it has seen `req_valid_o`, and it changes `ack_data_i` only in that same cycle. The responder inserts a chosen number of wait cycles before each completion, including zero, so that the stability property is exercised over long and short holds. Starts are driven only on falling edges, so a start issued in the middle of a sequence tests R10 without a race at the clock edge.

// File: rtl/iav_pkg.sv
package iav_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_ACK  = 2'b01,
    KIND_WR   = 2'b10,
    KIND_IDLE = 2'b11
  } kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_OP,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_TRAP,
    ST_PUSH_HI,
    ST_PUSH_LO
  } state_t;

  // restart code: bits 7:6 and 2:0 all ones
  function automatic logic is_restart(input logic [7:0] b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction

  // slot number carried in a restart code
  function automatic logic [2:0] restart_slot(input logic [7:0] b);
    return b[5:3];
  endfunction

  // stack address of a pre-decremented push
  function automatic logic [15:0] push_addr(input logic [15:0] sp);
    return sp - 16'd1;
  endfunction

endpackage

// File: rtl/iav_ctrl.sv
module iav_ctrl
  import iav_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CALL_OP = 8'hCD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          trap_i,
  input  logic          req_done_i,
  input  logic [DW-1:0] ack_byte_i,
  output state_t        state_o,
  output logic          accept_o,
  output logic          op_restart_o,
  output logic          op_bad_o,
  output logic          lo_fire_o,
  output logic          hi_fire_o,
  output logic          push_hi_fire_o,
  output logic          push_lo_fire_o
);

  state_t state_q, state_d;
  logic   fire, op_fire, op_call;

  assign fire           = req_done_i && (state_q != ST_IDLE);
  assign accept_o       = (state_q == ST_IDLE) && start_i;
  assign op_fire        = fire && (state_q == ST_ACK_OP);
  assign op_restart_o   = op_fire && is_restart(ack_byte_i[7:0]);
  assign op_call        = op_fire && !is_restart(ack_byte_i[7:0]) && (ack_byte_i == CALL_OP);
  assign op_bad_o       = op_fire && !op_restart_o && !op_call;
  assign lo_fire_o      = fire && (state_q == ST_ACK_LO);
  assign hi_fire_o      = fire && (state_q == ST_ACK_HI);
  assign push_hi_fire_o = fire && (state_q == ST_PUSH_HI);
  assign push_lo_fire_o = fire && (state_q == ST_PUSH_LO);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = trap_i ? ST_TRAP : ST_ACK_OP;
      ST_ACK_OP:  if (fire) begin
                    if (op_restart_o)  state_d = ST_PUSH_HI;
                    else if (op_call)  state_d = ST_ACK_LO;
                    else               state_d = ST_IDLE;
                  end
      ST_ACK_LO:  if (fire) state_d = ST_ACK_HI;
      ST_ACK_HI:  if (fire) state_d = ST_PUSH_HI;
      ST_TRAP:    if (fire) state_d = ST_PUSH_HI;
      ST_PUSH_HI: if (fire) state_d = ST_PUSH_LO;
      ST_PUSH_LO: if (fire) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: low address byte is always followed by the high byte fetch
  p_call_hi_after_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_fire_o |=> (state_o == ST_ACK_HI));

endmodule

// File: rtl/iav_dpath.sv
module iav_dpath
  import iav_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] TRAP_VEC = 16'h0024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  input  logic          trap_i,
  input  logic          accept_i,
  input  logic          op_restart_i,
  input  logic          op_bad_i,
  input  logic          lo_fire_i,
  input  logic          hi_fire_i,
  input  logic          push_hi_fire_i,
  input  logic          push_lo_fire_i,
  input  logic [DW-1:0] ack_byte_i,
  output logic [AW-1:0] ret_pc_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] new_pc_o,
  output logic [AW-1:0] new_sp_o
);

  logic [AW-1:0] ret_pc_q, sp_q, tgt_q, new_pc_q, new_sp_q;
  logic          done_q, err_q;
  logic [AW-1:0] rst_vec;

  assign rst_vec   = AW'(restart_slot(ack_byte_i[7:0])) << 3;
  assign wr_addr_o = push_addr(sp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
      sp_q     <= '0;
      tgt_q    <= '0;
    end else begin
      if (accept_i) begin
        ret_pc_q <= pc_i;
        sp_q     <= sp_i;
        tgt_q    <= TRAP_VEC;
      end
      if (op_restart_i)                    tgt_q <= rst_vec;
      if (lo_fire_i)                       tgt_q <= {tgt_q[AW-1:DW], ack_byte_i};
      if (hi_fire_i)                       tgt_q <= {ack_byte_i, tgt_q[DW-1:0]};
      if (push_hi_fire_i || push_lo_fire_i) sp_q  <= push_addr(sp_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      new_pc_q <= '0;
      new_sp_q <= '0;
    end else begin
      done_q <= push_lo_fire_i || op_bad_i;
      if (push_lo_fire_i) begin
        err_q    <= 1'b0;
        new_pc_q <= tgt_q;
        new_sp_q <= push_addr(sp_q);
      end else if (op_bad_i) begin
        err_q    <= 1'b1;
        new_pc_q <= ret_pc_q;
        new_sp_q <= sp_q;
      end
    end
  end

  assign ret_pc_o = ret_pc_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign new_pc_o = new_pc_q;
  assign new_sp_o = new_sp_q;

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: an error completion hands back the untouched PC and SP
  p_err_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> (new_pc_q == ret_pc_q) && (new_sp_q == sp_q));

endmodule

// File: rtl/iav_req.sv
module iav_req
  import iav_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  state_t        state_i,
  input  logic [AW-1:0] ret_pc_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          valid_o,
  output kind_t         kind_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  always_comb begin
    valid_o = 1'b1;
    kind_o  = KIND_NONE;
    addr_o  = ret_pc_i;
    data_o  = '0;
    unique case (state_i)
      ST_ACK_OP, ST_ACK_LO, ST_ACK_HI: kind_o = KIND_ACK;
      ST_TRAP:    kind_o = KIND_IDLE;
      ST_PUSH_HI: begin
        kind_o = KIND_WR;
        addr_o = wr_addr_i;
        data_o = ret_pc_i[AW-1:DW];
      end
      ST_PUSH_LO: begin
        kind_o = KIND_WR;
        addr_o = wr_addr_i;
        data_o = ret_pc_i[DW-1:0];
      end
      default: begin
        valid_o = 1'b0;
        addr_o  = '0;
      end
    endcase
  end

endmodule

// File: rtl/iav_seq.sv
module iav_seq
  import iav_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] CALL_OP = 8'hCD,
  parameter logic [2*DW-1:0] TRAP_VEC = 16'h0024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            trap_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] sp_i,
  output logic            req_valid_o,
  output logic [1:0]      req_kind_o,
  output logic [2*DW-1:0] req_addr_o,
  output logic [DW-1:0]   req_data_o,
  input  logic            req_done_i,
  input  logic [DW-1:0]   ack_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [2*DW-1:0] new_pc_o,
  output logic [2*DW-1:0] new_sp_o
);

  localparam int AW = 2 * DW;

  state_t        state_w;
  kind_t         kind_w;
  logic          accept_w, op_restart_w, op_bad_w, lo_fire_w, hi_fire_w;
  logic          push_hi_fire_w, push_lo_fire_w;
  logic [AW-1:0] ret_pc_w, wr_addr_w;
  logic          trap_path_q;

  iav_ctrl #(.DW(DW), .CALL_OP(CALL_OP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trap_i(trap_i),
    .req_done_i(req_done_i), .ack_byte_i(ack_data_i),
    .state_o(state_w), .accept_o(accept_w), .op_restart_o(op_restart_w),
    .op_bad_o(op_bad_w), .lo_fire_o(lo_fire_w), .hi_fire_o(hi_fire_w),
    .push_hi_fire_o(push_hi_fire_w), .push_lo_fire_o(push_lo_fire_w)
  );

  iav_dpath #(.DW(DW), .AW(AW), .TRAP_VEC(TRAP_VEC)) u_dpath (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .sp_i(sp_i), .trap_i(trap_i),
    .accept_i(accept_w), .op_restart_i(op_restart_w), .op_bad_i(op_bad_w),
    .lo_fire_i(lo_fire_w), .hi_fire_i(hi_fire_w),
    .push_hi_fire_i(push_hi_fire_w), .push_lo_fire_i(push_lo_fire_w),
    .ack_byte_i(ack_data_i), .ret_pc_o(ret_pc_w), .wr_addr_o(wr_addr_w),
    .done_o(done_o), .err_o(err_o), .new_pc_o(new_pc_o), .new_sp_o(new_sp_o)
  );

  iav_req #(.DW(DW), .AW(AW)) u_req (
    .state_i(state_w), .ret_pc_i(ret_pc_w), .wr_addr_i(wr_addr_w),
    .valid_o(req_valid_o), .kind_o(kind_w), .addr_o(req_addr_o),
    .data_o(req_data_o)
  );

  assign req_kind_o = kind_w;
  assign busy_o     = (state_w != ST_IDLE);

  // remembers which path the current sequence took, for the checks below
  always_ff @(posedge clk) begin
    if (!rst_n)        trap_path_q <= 1'b0;
    else if (accept_w) trap_path_q <= trap_i;
  end

  // R1: nothing is requested outside a sequence
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o);

  // R8: an unfinished request holds its fields
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_done_i) |=>
      (req_valid_o && $stable(req_kind_o) && $stable(req_addr_o) && $stable(req_data_o)));

  // R5: the low-byte write follows at the next lower stack address
  p_push_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_hi_fire_w |=>
      (req_valid_o && req_kind_o == KIND_WR && req_addr_o == $past(req_addr_o) - 1'b1));

  // R6: a trap sequence never acknowledges the device
  p_trap_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_path_q && req_valid_o) |-> (req_kind_o != KIND_ACK));

endmodule

// File: tb/tb_iav_seq.sv
module tb_iav_seq;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, trap_i = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic        req_valid_o, busy_o, done_o, err_o;
  logic [1:0]  req_kind_o;
  logic [15:0] req_addr_o, new_pc_o, new_sp_o;
  logic [7:0]  req_data_o;
  logic        req_done_i = 1'b0;
  logic [7:0]  ack_data_i = '0;

  iav_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trap_i(trap_i),
    .pc_i(pc_i), .sp_i(sp_i), .req_valid_o(req_valid_o),
    .req_kind_o(req_kind_o), .req_addr_o(req_addr_o), .req_data_o(req_data_o),
    .req_done_i(req_done_i), .ack_data_i(ack_data_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .new_pc_o(new_pc_o), .new_sp_o(new_sp_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    logic [1:0]  k;
    logic [15:0] a;
    logic [7:0]  d;
    string       tag;
  } rq_t;

  rq_t        exp_q[$];
  logic [7:0] byte_q[$];
  int total = 0, bad = 0;
  int cyc = 0, last_fire = -10, wait_n = 0, wcnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // bus responder and per-clock request comparison against the expected stream
  initial begin
    rq_t head;
    forever begin
      @(negedge clk);
      req_done_i = 1'b0;
      if (req_valid_o) begin
        if (exp_q.size() == 0) begin
          chk("R1", "unexpected request", 32'(req_valid_o), 32'd0);
        end else begin
          head = exp_q[0];
          chk(head.tag, "req kind", 32'(req_kind_o), 32'(head.k));
          chk(head.tag, "req addr", 32'(req_addr_o), 32'(head.a));
          chk(head.tag, "req data", 32'(req_data_o), 32'(head.d));
          if (wcnt == 0) begin
            req_done_i = 1'b1;
            if (head.k == 2'b01 && byte_q.size() > 0) ack_data_i = byte_q.pop_front();
            head = exp_q.pop_front();
            last_fire = cyc;
            wcnt = wait_n;
          end else begin
            wcnt--;
          end
        end
      end
    end
  end

  function automatic rq_t mk(input logic [1:0] k, input logic [15:0] a,
                             input logic [7:0] d, input string tag);
    rq_t r;
    r.k = k; r.a = a; r.d = d; r.tag = tag;
    return r;
  endfunction

  // expected pushes for a saved pc and starting sp (R5)
  task automatic exp_push(input logic [15:0] pc, input logic [15:0] sp);
    logic [15:0] s1, s2;
    s1 = sp - 16'd1;
    s2 = sp - 16'd2;
    exp_q.push_back(mk(2'b10, s1, pc[15:8], "R5"));
    exp_q.push_back(mk(2'b10, s2, pc[7:0], "R5"));
  endtask

  task automatic run(input string tag, input bit trap, input logic [15:0] pc,
                     input logic [15:0] sp, input int waits,
                     input logic [15:0] exp_pc, input logic [15:0] exp_sp,
                     input bit exp_err, input bit poke_mid);
    bit seen;
    seen = 1'b0;
    wait_n = waits;
    wcnt = waits;
    @(negedge clk);
    start_i = 1'b1; trap_i = trap; pc_i = pc; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0; trap_i = 1'b0;
    pc_i = ~pc; sp_i = ~sp;
    chk("R2", "busy after start", 32'(busy_o), 32'd1);
    if (poke_mid) begin
      @(negedge clk);
      start_i = 1'b1; trap_i = ~trap; pc_i = 16'h5A5A; sp_i = 16'hA5A5;
      @(negedge clk);
      start_i = 1'b0; trap_i = 1'b0;
    end
    for (int i = 0; i < 500; i++) begin
      if (done_o) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk("R9", "done seen", 32'(seen), 32'd1);
    chk("R9", "done one cycle after last completion", 32'(cyc), 32'(last_fire + 1));
    chk(tag, "new pc", 32'(new_pc_o), 32'(exp_pc));
    chk(tag, "new sp", 32'(new_sp_o), 32'(exp_sp));
    chk(tag, "err flag", 32'(err_o), 32'(exp_err));
    chk(tag, "all requests issued", 32'(exp_q.size()), 32'd0);
    @(negedge clk);
    chk("R9", "done drops", 32'(done_o), 32'd0);
    chk("R10", "idle after sequence", 32'(busy_o), 32'd0);
    exp_q.delete();
    byte_q.delete();
  endtask

  task automatic do_restart(input logic [7:0] code, input logic [15:0] pc,
                            input logic [15:0] sp, input int waits, input bit poke);
    logic [15:0] vec;
    vec = {10'd0, code[5:3], 3'd0};
    exp_q.push_back(mk(2'b01, pc, 8'h00, "R2"));
    byte_q.push_back(code);
    exp_push(pc, sp);
    run("R3", 1'b0, pc, sp, waits, vec, sp - 16'd2, 1'b0, poke);
  endtask

  task automatic do_call(input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] pc, input logic [15:0] sp, input int waits);
    exp_q.push_back(mk(2'b01, pc, 8'h00, "R2"));
    exp_q.push_back(mk(2'b01, pc, 8'h00, "R4"));
    exp_q.push_back(mk(2'b01, pc, 8'h00, "R4"));
    byte_q.push_back(8'hCD);
    byte_q.push_back(lo);
    byte_q.push_back(hi);
    exp_push(pc, sp);
    run("R4", 1'b0, pc, sp, waits, {hi, lo}, sp - 16'd2, 1'b0, 1'b0);
  endtask

  task automatic do_trap(input logic [15:0] pc, input logic [15:0] sp, input int waits);
    exp_q.push_back(mk(2'b11, pc, 8'h00, "R6"));
    exp_push(pc, sp);
    run("R6", 1'b1, pc, sp, waits, 16'h0024, sp - 16'd2, 1'b0, 1'b0);
  endtask

  task automatic do_bad(input logic [7:0] code, input logic [15:0] pc,
                        input logic [15:0] sp, input int waits);
    exp_q.push_back(mk(2'b01, pc, 8'h00, "R7"));
    byte_q.push_back(code);
    run("R7", 1'b0, pc, sp, waits, pc, sp, 1'b1, 1'b0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    total++;
    bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "req_valid in reset", 32'(req_valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_valid after reset", 32'(req_valid_o), 32'd0);
    chk("R1", "busy after reset", 32'(busy_o), 32'd0);
    chk("R1", "done after reset", 32'(done_o), 32'd0);
    chk("R1", "err after reset", 32'(err_o), 32'd0);

    do_restart(8'hEF, 16'h1234, 16'h8000, 0, 1'b0);
    do_restart(8'hC7, 16'hBEEF, 16'h0001, 2, 1'b0);   // SP wraps
    do_restart(8'hFF, 16'h0102, 16'hF000, 3, 1'b1);   // R10 start mid-sequence
    do_call(8'h56, 8'h9A, 16'hABCD, 16'h4000, 1);
    do_call(8'hFF, 8'h00, 16'h00FF, 16'h0000, 0);
    do_trap(16'h0F0F, 16'h2000, 0);
    do_trap(16'hFFFF, 16'h0002, 4);
    do_bad(8'h00, 16'h3333, 16'h7777, 0);
    do_bad(8'hC6, 16'h4444, 16'h1000, 2);
    do_bad(8'hCC, 16'h5555, 16'h0000, 1);
    do_restart(8'hD7, 16'h8001, 16'h1002, 0, 1'b0);

    repeat (3) @(negedge clk);
    chk("R1", "quiet at end", 32'(req_valid_o), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule